// File: doc/BRIEF.md
# Integer Execute ALU with Overflow Trap

This block is the combinational integer execute stage of a 32-bit scalar core. It takes two register operands, a 16-bit immediate field, a 5-bit constant shift amount and a 5-bit operation code. It returns the value to write back and a flag that reports signed overflow. It also extends the immediate itself: arithmetic and compare operations sign-extend it, and bitwise operations zero-extend it.

When the trapping forms overflow, the flag rises and the write enable drops, so the destination register keeps its old value. The exception logic downstream decides what to do with the flag. Codes outside the defined set produce a zero result with the write enable low.

Top module: `alu_exec`

## Requirements
- R1: The add and subtract codes return A+B and A-B modulo 2^32: ADD=0, ADDU=1, SUB=2, SUBU=3, ADDI=10, ADDIU=11 (the immediate forms use the extended immediate in place of B).
- R2: `ovf_trap` is 1 only for codes 0, 2 and 10 when the two's complement result does not fit in 32 bits. It is never 1 for any other code, whatever the operands.
- R3: `wr_en` is 0 whenever `ovf_trap` is 1, and 1 for every defined code (0..23) without overflow. Codes 24..31 give `result`=0, `ovf_trap`=0 and `wr_en`=0.
- R4: ADDI, ADDIU, SLTI=12 and SLTIU=13 sign-extend the 16-bit immediate to 32 bits, including the unsigned forms.
- R5: ANDI=14, ORI=15 and XORI=16 zero-extend the immediate before the bitwise AND, OR and XOR with A.
- R6: LUI=17 returns the immediate in bits 31..16 and zeros in bits 15..0.
- R7: SLT=8 and SLTI compare A against the second operand as signed values; SLTU=9 and SLTIU compare them as unsigned values. The result is 1 or 0 in a full word.
- R8: AND=4, OR=5, XOR=6 and NOR=7 apply bitwise to A and B, with NOR returning the inverse of A|B.
- R9: SLL=18, SRL=19 and SRA=20 shift B by `shamt` (0..31). SRL fills with zeros and SRA fills with copies of B[31].
- R10: SLLV=21, SRLV=22 and SRAV=23 shift B by A[4:0] and ignore the upper bits of A. SRAV fills with the sign bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op | input | 5 | Operation code |
| src_a | input | 32 | First register operand; supplies the amount for variable shifts |
| src_b | input | 32 | Second register operand; the operand that shifts act on |
| imm16 | input | 16 | Raw immediate field |
| shamt | input | 5 | Constant shift amount |
| result | output | 32 | Write-back value |
| ovf_trap | output | 1 | Signed overflow on a trapping form |
| wr_en | output | 1 | Destination write enable |

## Verification
The block has no registers, so every output is due in the same cycle as the operands that produce it. The driver applies a stimulus just after a rising edge and queues the expected result, flag and enable. The monitor pops that entry at the following falling edge, after the logic has settled and before the next stimulus arrives. The expected values come from a reference model that detects overflow by doing the sum in 64-bit signed arithmetic and checking the range. This method differs from the sign-bit test that the design uses.

// File: rtl/alu_exec.sv
module alu_exec #(
  parameter int XLEN  = 32,
  parameter int IMM_W = 16
) (
  input  logic [4:0]       op,
  input  logic [XLEN-1:0]  src_a,
  input  logic [XLEN-1:0]  src_b,
  input  logic [IMM_W-1:0] imm16,
  input  logic [4:0]       shamt,
  output logic [XLEN-1:0]  result,
  output logic             ovf_trap,
  output logic             wr_en
);
  localparam int MSB  = XLEN - 1;
  localparam int SH_W = $clog2(XLEN);

  localparam logic [4:0] ADD = 5'd0,  ADDU = 5'd1,  SUB = 5'd2,  SUBU = 5'd3;
  localparam logic [4:0] AND = 5'd4,  OR   = 5'd5,  XOR = 5'd6,  NOR  = 5'd7;
  localparam logic [4:0] SLT = 5'd8,  SLTU = 5'd9,  ADDI = 5'd10, ADDIU = 5'd11;
  localparam logic [4:0] SLTI = 5'd12, SLTIU = 5'd13, ANDI = 5'd14, ORI = 5'd15;
  localparam logic [4:0] XORI = 5'd16, LUI = 5'd17, SLL = 5'd18, SRL = 5'd19;
  localparam logic [4:0] SRA = 5'd20, SLLV = 5'd21, SRLV = 5'd22, SRAV = 5'd23;

  logic            sext_op, zext_op, add_ovf, sub_ovf, known;
  logic [XLEN-1:0] imm_s, imm_z, opb, sum, diff;
  logic [SH_W-1:0] csh, vsh;

  assign sext_op = op inside {ADDI, ADDIU, SLTI, SLTIU};
  assign zext_op = op inside {ANDI, ORI, XORI};
  assign imm_s   = {{(XLEN-IMM_W){imm16[IMM_W-1]}}, imm16};
  assign imm_z   = {{(XLEN-IMM_W){1'b0}}, imm16};
  assign opb     = sext_op ? imm_s : (zext_op ? imm_z : src_b);

  assign sum  = src_a + opb;
  assign diff = src_a - opb;
  assign add_ovf = (src_a[MSB] == opb[MSB]) && (sum[MSB] != src_a[MSB]);
  assign sub_ovf = (src_a[MSB] != opb[MSB]) && (diff[MSB] != src_a[MSB]);

  assign csh = shamt[SH_W-1:0];
  assign vsh = src_a[SH_W-1:0];

  always_comb begin
    known  = 1'b1;
    result = '0;
    case (op)
      ADD, ADDU, ADDI, ADDIU: result = sum;
      SUB, SUBU:              result = diff;
      AND, ANDI:              result = src_a & opb;
      OR,  ORI:               result = src_a | opb;
      XOR, XORI:              result = src_a ^ opb;
      NOR:                    result = ~(src_a | opb);
      SLT, SLTI:              result = {{MSB{1'b0}}, $signed(src_a) < $signed(opb)};
      SLTU, SLTIU:            result = {{MSB{1'b0}}, src_a < opb};
      LUI:                    result = {imm16, {(XLEN-IMM_W){1'b0}}};
      SLL:                    result = src_b << csh;
      SRL:                    result = src_b >> csh;
      SRA:                    result = $unsigned($signed(src_b) >>> csh);
      SLLV:                   result = src_b << vsh;
      SRLV:                   result = src_b >> vsh;
      SRAV:                   result = $unsigned($signed(src_b) >>> vsh);
      default:                known  = 1'b0;
    endcase
  end

  assign ovf_trap = ((op == ADD || op == ADDI) && add_ovf) || (op == SUB && sub_ovf);
  assign wr_en    = known & ~ovf_trap;

  always_comb begin
    if (!$isunknown({op, src_a, src_b, imm16, shamt})) begin
      p_trap_ops_r2: assert (!ovf_trap || op inside {ADD, SUB, ADDI});
      p_trap_blocks_write_r3: assert (!(ovf_trap && wr_en));
      p_slt_bit_r7: assert (!(op inside {SLT, SLTU, SLTI, SLTIU}) || result[MSB:1] == '0);
      p_lui_low_zero_r6: assert (op != LUI || result[XLEN-IMM_W-1:0] == '0);
      p_sll_zero_r9: assert (!(op == SLL && shamt == 5'd0) || result == src_b);
    end
  end
endmodule

// File: tb/sim_alu_exec.sv
`timescale 1ns/1ps
module sim_alu_exec;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic [4:0]  op = '0;
  logic [31:0] src_a = '0, src_b = '0;
  logic [15:0] imm16 = '0;
  logic [4:0]  shamt = '0;
  logic [31:0] result;
  logic        ovf_trap, wr_en;

  alu_exec u0 (.op(op), .src_a(src_a), .src_b(src_b), .imm16(imm16), .shamt(shamt),
               .result(result), .ovf_trap(ovf_trap), .wr_en(wr_en));

  typedef struct {
    logic [31:0] res;
    logic        trap;
    logic        we;
    string       tag;
  } item_t;

  item_t q[$];
  int total = 0, bad = 0;
  bit done = 0;

  function automatic string tag_of(input logic [4:0] o);
    if (o <= 5'd3 || o == 5'd10 || o == 5'd11) return "R1";
    if (o <= 5'd7) return "R8";
    if (o == 5'd8 || o == 5'd9 || o == 5'd12 || o == 5'd13) return "R7";
    if (o <= 5'd16) return "R5";
    if (o == 5'd17) return "R6";
    if (o <= 5'd20) return "R9";
    if (o <= 5'd23) return "R10";
    return "R3";
  endfunction

  function automatic item_t model(input logic [4:0] o, input logic [31:0] a, input logic [31:0] b,
                                  input logic [15:0] im, input logic [4:0] sh);
    item_t it;
    logic [31:0] se, ze, bb;
    longint s;
    se = {{16{im[15]}}, im};
    ze = {16'h0, im};
    bb = (o >= 5'd10 && o <= 5'd13) ? se : b;
    it.res = '0; it.trap = 1'b0; it.we = 1'b1; it.tag = "";
    case (o)
      5'd0, 5'd1, 5'd10, 5'd11: begin
        it.res = a + bb;
        s = longint'($signed(a)) + longint'($signed(bb));
        it.trap = (o == 5'd0 || o == 5'd10) && (s > 64'sd2147483647 || s < -64'sd2147483648);
      end
      5'd2, 5'd3: begin
        it.res = a - b;
        s = longint'($signed(a)) - longint'($signed(b));
        it.trap = (o == 5'd2) && (s > 64'sd2147483647 || s < -64'sd2147483648);
      end
      5'd4:  it.res = a & b;
      5'd5:  it.res = a | b;
      5'd6:  it.res = a ^ b;
      5'd7:  it.res = ~(a | b);
      5'd8, 5'd12: it.res = ($signed(a) < $signed(bb)) ? 32'd1 : 32'd0;
      5'd9, 5'd13: it.res = (a < bb) ? 32'd1 : 32'd0;
      5'd14: it.res = a & ze;
      5'd15: it.res = a | ze;
      5'd16: it.res = a ^ ze;
      5'd17: it.res = {im, 16'h0};
      5'd18: it.res = b << sh;
      5'd19: it.res = b >> sh;
      5'd20: it.res = $unsigned($signed(b) >>> sh);
      5'd21: it.res = b << a[4:0];
      5'd22: it.res = b >> a[4:0];
      5'd23: it.res = $unsigned($signed(b) >>> a[4:0]);
      default: it.we = 1'b0;
    endcase
    if (it.trap) it.we = 1'b0;
    return it;
  endfunction

  task automatic send(input logic [4:0] o, input logic [31:0] a, input logic [31:0] b,
                      input logic [15:0] im, input logic [4:0] sh, input string tag);
    item_t it;
    @(posedge clk);
    #0.5;
    op = o; src_a = a; src_b = b; imm16 = im; shamt = sh;
    it = model(o, a, b, im, sh);
    it.tag = tag;
    q.push_back(it);
  endtask

  always @(negedge clk) begin
    if (q.size() > 0) begin
      item_t e;
      e = q.pop_front();
      total += 3;
      if (result !== e.res) begin
        bad++;
        $display("FAIL %s op=%0d result actual=%h expected=%h", e.tag, op, result, e.res);
      end
      if (ovf_trap !== e.trap) begin
        bad++;
        $display("FAIL R2 op=%0d a=%h b=%h imm=%h trap actual=%b expected=%b",
                 op, src_a, src_b, imm16, ovf_trap, e.trap);
      end
      if (wr_en !== e.we) begin
        bad++;
        $display("FAIL R3 op=%0d wr_en actual=%b expected=%b", op, wr_en, e.we);
      end
    end
  end

  initial begin
    #400000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] cv[5];
    cv[0] = 32'h7FFFFFFF; cv[1] = 32'h80000000; cv[2] = 32'hFFFFFFFF;
    cv[3] = 32'h0; cv[4] = 32'h1;
    repeat (4) @(posedge clk);
    rst = 1'b0;
    send(5'd0, 32'h0, 32'h0, 16'h0, 5'd0, "R1");
    // R2 boundaries
    send(5'd0, 32'h7FFFFFFF, 32'h1, 16'h0, 5'd0, "R2");
    send(5'd1, 32'h7FFFFFFF, 32'h1, 16'h0, 5'd0, "R2");
    send(5'd2, 32'h80000000, 32'h1, 16'h0, 5'd0, "R2");
    send(5'd3, 32'h80000000, 32'h1, 16'h0, 5'd0, "R2");
    send(5'd10, 32'h7FFFFFFF, 32'h0, 16'h0001, 5'd0, "R2");
    send(5'd11, 32'h7FFFFFFF, 32'h0, 16'h0001, 5'd0, "R2");
    send(5'd10, 32'h80000000, 32'h0, 16'hFFFF, 5'd0, "R2");
    // R4 sign extension on unsigned forms
    send(5'd11, 32'h00000010, 32'h0, 16'hFFFE, 5'd0, "R4");
    send(5'd13, 32'hFFFFFFFE, 32'h0, 16'hFFFF, 5'd0, "R4");
    send(5'd12, 32'hFFFFFFFE, 32'h0, 16'hFFFF, 5'd0, "R4");
    // R5 zero extension
    send(5'd14, 32'hFFFFFFFF, 32'h0, 16'h8000, 5'd0, "R5");
    send(5'd15, 32'h0, 32'h0, 16'hF00F, 5'd0, "R5");
    send(5'd16, 32'hFFFF0000, 32'h0, 16'h8001, 5'd0, "R5");
    send(5'd17, 32'hDEADBEEF, 32'h1234, 16'hA5C3, 5'd0, "R6");
    // R7 signed vs unsigned
    send(5'd8, 32'hFFFFFFFF, 32'h1, 16'h0, 5'd0, "R7");
    send(5'd9, 32'hFFFFFFFF, 32'h1, 16'h0, 5'd0, "R7");
    send(5'd8, 32'h2, 32'h1, 16'h0, 5'd0, "R7");
    send(5'd7, 32'h0F0F0000, 32'h000000F0, 16'h0, 5'd0, "R8");
    // R9 and R10 shifts
    send(5'd20, 32'h0, 32'h80000000, 16'h0, 5'd31, "R9");
    send(5'd19, 32'h0, 32'h80000000, 16'h0, 5'd31, "R9");
    send(5'd18, 32'h0, 32'h00000001, 16'h0, 5'd0, "R9");
    send(5'd23, 32'hFFFFFFE5, 32'h80000000, 16'h0, 5'd0, "R10");
    send(5'd21, 32'h00000025, 32'h00000003, 16'h0, 5'd0, "R10");
    send(5'd22, 32'h0000003F, 32'hFFFFFFFF, 16'h0, 5'd0, "R10");
    // R3 undefined codes
    send(5'd24, 32'h1, 32'h2, 16'h3, 5'd4, "R3");
    send(5'd31, 32'hFFFFFFFF, 32'hFFFFFFFF, 16'hFFFF, 5'd31, "R3");
    // corner values across arithmetic codes
    for (int i = 0; i < 5; i++)
      for (int j = 0; j < 5; j++) begin
        send(5'd0, cv[i], cv[j], 16'h0, 5'd0, "R2");
        send(5'd2, cv[i], cv[j], 16'h0, 5'd0, "R2");
        send(5'd3, cv[i], cv[j], 16'h0, 5'd0, "R1");
        send(5'd8, cv[i], cv[j], 16'h0, 5'd0, "R7");
        send(5'd9, cv[i], cv[j], 16'h0, 5'd0, "R7");
        send(5'd10, cv[i], 32'h0, cv[j][15:0], 5'd0, "R4");
      end
    for (int k = 0; k < 1500; k++) begin
      logic [4:0] o;
      o = 5'($urandom_range(0, 25));
      send(o, $urandom, $urandom, 16'($urandom), 5'($urandom), tag_of(o));
    end
    @(posedge clk);
    @(posedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule